// File: doc/BRIEF.md
# LIN Frame Transmitter with Error Injection

This block sends one LIN frame on a single serial line at a fixed bit rate. A frame starts with a break and its delimiter. A sync character and a protected identifier follow, which together form the header. The response comes next: up to `MAX_BYTES` data characters and a checksum character. A second mode, selected per frame, sends the data characters alone as plain asynchronous characters with even parity and no header or checksum.

A fault word can corrupt chosen fields on purpose, so that the error detection of a receiver can be exercised. The targets are:
- the sync value and the sync stop bit,
- the identifier parity and the identifier stop bit,
- the data stop bits,
- the checksum value and the checksum stop bit.

The fault word only takes effect when its arm bit is set and its channel field matches the `CHANNEL` parameter of this instance. The block samples the fault word, the identifier, the data and the mode when a frame is accepted.

A frame is requested with a one-cycle `start` strobe. `busy` stays high while the frame is sent. A one-cycle `done` pulse marks the end of the last stop bit.

Top module: `lin_fault_tx`

## Requirements
- R1: While reset is held and after reset, `txd` is 1, and `done` and `busy` are 0.
- R2: In LIN mode a frame is sent in this order:
  - `BREAK_BITS` zero bits, then one delimiter bit at 1;
  - the sync character 0x55;
  - the protected identifier;
  - the data characters, byte 0 first (byte k is `data_in[8k+7:8k]`);
  - the checksum.
  Each character is a start bit 0, 8 data bits LSB first and a stop bit 1. Every bit lasts `CLKS_PER_BIT` cycles.
- R3: The protected identifier is {P1, P0, ident[5:0]} with P0 = ident0^ident1^ident2^ident4 and P1 = !(ident1^ident3^ident4^ident5).
- R4: The checksum is the bitwise inverse of the 8-bit sum of the data bytes, with each carry out added back in. When `enh_sum` is 1, the protected identifier as sent is added first.
- R5: With `uart_mode` = 1, only the data characters are sent. Each character has 11 bits: start 0, 8 data bits LSB first, even parity (the XOR of the data bits), and stop 1.
- R6: `fault_ctl` has this layout:
  - [0]: arm;
  - [5:1]: channel;
  - [6]: sync value;
  - [7]: sync stop;
  - [8]: parity;
  - [9]: identifier stop;
  - [10]: data stop;
  - [11]: checksum value;
  - [12]: checksum stop.
  Bits [12:6] take effect only when [0] is 1 and [5:1] equals `CHANNEL`. Otherwise the frame is sent unchanged.
- R7: With the sync value fault, the sync character carries 0x00. With the sync stop fault, its stop bit is 0.
- R8: With the parity fault, P1 is sent as ident1^ident3^ident4^ident5 in LIN mode. In UART mode the parity bit of every character is inverted instead.
- R9: With the identifier stop fault, the stop bit of the protected identifier is 0.
- R10: With the data stop fault, the stop bit of every data character is 0, in both modes.
- R11: With the checksum value fault, all 8 checksum bits are inverted. With the checksum stop fault, the checksum stop bit is 0.
- R12: `done` pulses for one cycle after the last bit. At that point `txd` returns to 1 and `busy` falls. A `start` while `busy` is high is ignored.
- R13: `byte_cnt` values above `MAX_BYTES` are treated as `MAX_BYTES`. In LIN mode a count of 0 sends only the break and the header. In UART mode a count of 0 sends nothing and gives a `done` pulse in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request strobe |
| ident | input | 6 | Frame identifier |
| data_in | input | MAX_BYTES*8 | Data bytes, byte 0 in the low bits |
| byte_cnt | input | $clog2(MAX_BYTES+1) | Number of data bytes |
| uart_mode | input | 1 | 1: plain characters with parity, 0: LIN frame |
| enh_sum | input | 1 | Include the identifier in the checksum |
| fault_ctl | input | 13 | Fault injection control word |
| txd | output | 1 | Serial line, idle high |
| done | output | 1 | End-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
Two pairs of functions can act on the same cycle.

The first pair is a new `start` request and a character or bit boundary of a frame already being sent. The bench raises `start` at a bit boundary in the middle of a frame, with a different identifier, count and mode on the inputs. It then requires the captured bit stream and the `done` timing to match the first frame exactly.

The second pair is the parity fault and the enhanced checksum. Both act on the identifier in the cycle the identifier character is loaded. The bench combines them so that the expected checksum must cover the corrupted identifier.

// File: rtl/lin_fault_pkg.sv
`timescale 1ns/1ps
package lin_fault_pkg;

  localparam int FAULT_W = 13;
  localparam logic [7:0] SYNC_BYTE = 8'h55;

  // Corruption flags, MSB first
  typedef struct packed {
    logic sum_stop_low;
    logic sum_flip;
    logic data_stop_low;
    logic pid_stop_low;
    logic par_flip;
    logic sync_stop_low;
    logic sync_zero;
  } flt_bits_t;

  typedef struct packed {
    flt_bits_t  bits;
    logic [4:0] chan;
    logic       arm;
  } fault_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ARM, PH_BRK, PH_SYNC, PH_PID, PH_DATA, PH_SUM
  } phase_t;

endpackage

// File: rtl/lin_fault_baud.sv
`timescale 1ns/1ps
module lin_fault_baud #(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= tick ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/lin_fault_pid.sv
`timescale 1ns/1ps
module lin_fault_pid (
  input  logic [5:0] id,
  input  logic       flip,
  output logic [7:0] pid
);
  logic p0, p1;

  always_comb begin
    p0  = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1  = ~(id[1] ^ id[3] ^ id[4] ^ id[5]) ^ flip;
    pid = {p1, p0, id};
  end
endmodule

// File: rtl/lin_fault_csum.sv
`timescale 1ns/1ps
module lin_fault_csum (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum_inv
);
  logic [7:0] acc;
  logic [8:0] wide;

  assign wide    = {1'b0, acc} + {1'b0, din};
  assign sum_inv = ~acc;

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (add)
      acc <= wide[7:0] + {7'd0, wide[8]};
  end
endmodule

// File: rtl/lin_fault_tx.sv
`timescale 1ns/1ps
module lin_fault_tx
  import lin_fault_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 4,
  parameter int         BREAK_BITS   = 13,
  parameter int         MAX_BYTES    = 8,
  parameter logic [4:0] CHANNEL      = 5'd3,
  localparam int        CNT_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [5:0]             ident,
  input  logic [MAX_BYTES*8-1:0] data_in,
  input  logic [CNT_W-1:0]       byte_cnt,
  input  logic                   uart_mode,
  input  logic                   enh_sum,
  input  logic [FAULT_W-1:0]     fault_ctl,
  output logic                   txd,
  output logic                   done,
  output logic                   busy
);
  localparam int W  = (BREAK_BITS + 1 > 11) ? BREAK_BITS + 1 : 11;
  localparam int LW = $clog2(W + 1);

  phase_t                 phase, nxt;
  logic [W-1:0]           sh, chr;
  logic [LW-1:0]          left, len;
  logic [CNT_W-1:0]       idx, nb;
  logic [MAX_BYTES*8-1:0] dat_q;
  logic [5:0]             id_q;
  logic                   uart_q, enh_q;
  flt_bits_t              flt_q;
  logic                   txd_q, done_q, busy_q;

  fault_t     fw;
  logic       hit, tick, step, adv, fin, c_add, data_sel, par;
  logic [7:0] pid, byte_at, c_din, sum_inv, sync_v;

  assign fw      = fault_t'(fault_ctl);
  assign hit     = fw.arm && (fw.chan == CHANNEL);
  assign byte_at = dat_q[idx*8 +: 8];
  assign par     = (^byte_at) ^ flt_q.par_flip;
  assign sync_v  = flt_q.sync_zero ? 8'h00 : SYNC_BYTE;
  assign step    = tick || (phase == PH_ARM);
  assign adv     = (phase == PH_ARM) || (tick && left == LW'(1));

  lin_fault_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk(clk), .rst(rst), .clr(phase == PH_ARM), .en(busy_q), .tick(tick)
  );

  lin_fault_pid u_pid (
    .id(id_q), .flip(flt_q.par_flip && !uart_q), .pid(pid)
  );

  lin_fault_csum u_sum (
    .clk(clk), .rst(rst), .clr(phase == PH_IDLE), .add(adv && c_add),
    .din(c_din), .sum_inv(sum_inv)
  );

  // Next character selection
  always_comb begin
    nxt      = PH_IDLE;
    fin      = 1'b0;
    chr      = '0;
    len      = LW'(10);
    c_add    = 1'b0;
    c_din    = byte_at;
    data_sel = 1'b0;
    case (phase)
      PH_ARM: begin
        if (uart_q) data_sel = 1'b1;
        else begin
          nxt = PH_BRK;
          chr = W'({1'b1, {BREAK_BITS{1'b0}}});
          len = LW'(BREAK_BITS + 1);
        end
      end
      PH_BRK: begin
        nxt = PH_SYNC;
        chr = W'({~flt_q.sync_stop_low, sync_v, 1'b0});
      end
      PH_SYNC: begin
        nxt   = PH_PID;
        chr   = W'({~flt_q.pid_stop_low, pid, 1'b0});
        c_add = enh_q;
        c_din = pid;
      end
      PH_PID, PH_DATA: begin
        if (idx < nb) data_sel = 1'b1;
        else if (uart_q || phase == PH_PID) fin = 1'b1;
        else begin
          nxt = PH_SUM;
          chr = W'({~flt_q.sum_stop_low, sum_inv ^ {8{flt_q.sum_flip}}, 1'b0});
        end
      end
      default: fin = 1'b1;
    endcase
    if (data_sel) begin
      nxt   = PH_DATA;
      c_add = 1'b1;
      if (uart_q) begin
        chr = W'({~flt_q.data_stop_low, par, byte_at, 1'b0});
        len = LW'(11);
      end else begin
        chr = W'({~flt_q.data_stop_low, byte_at, 1'b0});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      sh     <= '0;
      left   <= '0;
      idx    <= '0;
      nb     <= '0;
      dat_q  <= '0;
      id_q   <= '0;
      uart_q <= 1'b0;
      enh_q  <= 1'b0;
      flt_q  <= '0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          if (uart_mode && byte_cnt == '0) begin
            done_q <= 1'b1;
          end else begin
            phase  <= PH_ARM;
            busy_q <= 1'b1;
            idx    <= '0;
            nb     <= (byte_cnt > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byte_cnt;
            dat_q  <= data_in;
            id_q   <= ident;
            uart_q <= uart_mode;
            enh_q  <= enh_sum;
            flt_q  <= hit ? fw.bits : '0;
          end
        end
      end else if (adv) begin
        if (fin) begin
          phase  <= PH_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          txd_q  <= 1'b1;
        end else begin
          phase <= nxt;
          txd_q <= chr[0];
          sh    <= chr >> 1;
          left  <= len;
          if (nxt == PH_DATA) idx <= idx + CNT_W'(1);
        end
      end else if (tick) begin
        txd_q <= sh[0];
        sh    <= sh >> 1;
        left  <= left - LW'(1);
      end
    end
  end

  assign txd  = txd_q;
  assign done = done_q;
  assign busy = busy_q;
endmodule

// File: rtl/lin_fault_tx_chk.sv
`timescale 1ns/1ps
module lin_fault_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic txd,
  input logic done,
  input logic busy,
  input logic step
);
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);                                           // R1

  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> !txd);                                    // R2

  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (txd != $past(txd))) |-> $past(step)); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy || done));                     // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $past(start)));                        // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && txd));                                 // R12
endmodule

bind lin_fault_tx lin_fault_tx_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .txd(txd),
  .done(done), .busy(busy), .step(step)
);

// File: tb/sim_lin_fault_tx.sv
`timescale 1ns/1ps
module sim_lin_fault_tx;
  localparam int         CPB  = 4;
  localparam int         MAXB = 8;
  localparam int         CW   = $clog2(MAXB + 1);
  localparam logic [4:0] CH   = 5'd3;

  logic            clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [5:0]      ident = '0;
  logic [MAXB*8-1:0] data = '0;
  logic [CW-1:0]   cnt = '0;
  logic            uart = 1'b0, enh = 1'b0;
  logic [12:0]     fctl = '0;
  wire             txd, done, busy;

  int  n_chk = 0, n_bad = 0;
  bit  exp_b [256];
  bit  act_b [256];
  int  exp_n;

  lin_fault_tx #(.CLKS_PER_BIT(CPB), .BREAK_BITS(13), .MAX_BYTES(MAXB), .CHANNEL(CH)) u0 (
    .clk(clk), .rst(rst), .start(start), .ident(ident), .data_in(data),
    .byte_cnt(cnt), .uart_mode(uart), .enh_sum(enh), .fault_ctl(fctl),
    .txd(txd), .done(done), .busy(busy)
  );

  always #2 clk = ~clk;

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [12:0] fw(input bit arm, input logic [4:0] ch,
      input bit sz, input bit ss, input bit pf, input bit ps,
      input bit ds, input bit sf, input bit st);
    return {st, sf, ds, ps, pf, ss, sz, ch, arm};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [10:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_b[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic build_exp();
    bit on;
    int nb;
    logic [7:0] pid, b, sum;
    logic [8:0] w;
    on = fctl[0] && (fctl[5:1] == CH);
    nb = (int'(cnt) > MAXB) ? MAXB : int'(cnt);
    exp_n = 0;
    if (!uart) begin
      for (int i = 0; i < 13; i++) push(11'd0, 1);
      push(11'd1, 1);
      push({1'b0, !(on && fctl[7]), (on && fctl[6]) ? 8'h00 : 8'h55, 1'b0}, 10);
      pid[5:0] = ident;
      pid[6]   = ident[0] ^ ident[1] ^ ident[2] ^ ident[4];
      pid[7]   = !(ident[1] ^ ident[3] ^ ident[4] ^ ident[5]) ^ (on && fctl[8]);
      push({1'b0, !(on && fctl[9]), pid, 1'b0}, 10);
      sum = enh ? pid : 8'h00;
      for (int k = 0; k < nb; k++) begin
        b = data[k*8 +: 8];
        w = {1'b0, sum} + {1'b0, b};
        sum = w[7:0] + {7'd0, w[8]};
        push({1'b0, !(on && fctl[10]), b, 1'b0}, 10);
      end
      if (nb > 0) push({1'b0, !(on && fctl[12]), ~sum ^ {8{on && fctl[11]}}, 1'b0}, 10);
    end else begin
      for (int k = 0; k < nb; k++) begin
        b = data[k*8 +: 8];
        push({!(on && fctl[10]), (^b) ^ (on && fctl[8]), b, 1'b0}, 11);
      end
    end
  endtask

  task automatic run_frame(input string req, input bit poke);
    int bad_i;
    build_exp();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    @(posedge clk);
    for (int j = 0; j < exp_n; j++) begin
      @(negedge clk);
      act_b[j] = txd;
      if (poke && j == 20) begin
        start = 1'b1; ident = ~ident; cnt = CW'(1); uart = ~uart;
      end
      if (poke && j == 21) start = 1'b0;
      repeat (CPB - 1) @(negedge clk);
    end
    bad_i = -1;
    for (int j = exp_n - 1; j >= 0; j--) if (act_b[j] != exp_b[j]) bad_i = j;
    check(bad_i < 0, req, $sformatf("bit stream (first bad bit %0d of %0d)", bad_i, exp_n),
          bad_i < 0 ? 0 : int'(act_b[bad_i]), bad_i < 0 ? 0 : int'(exp_b[bad_i]));
    @(negedge clk);
    check(done && txd, "R12", "done pulse with idle line", {done, txd}, 3);
    @(negedge clk);
    check(!done && !busy, "R12", "done single cycle, busy low", {done, busy}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(txd && !done && !busy, "R1", "outputs during reset", {txd, done, busy}, 4);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd && !done && !busy, "R1", "outputs after reset", {txd, done, busy}, 4);
  endtask

  task automatic t_lin_basic();
    ident = 6'h3C; data = 64'h0000_0000_00A5_1234; cnt = 4'd3; uart = 0; enh = 0; fctl = '0;
    run_frame("R2 R3 R4 classic", 0);
    ident = 6'h2B; data = 64'h0000_0000_0000_0081; cnt = 4'd1;
    run_frame("R3", 0);
  endtask

  task automatic t_lin_enh();
    ident = 6'h11; data = 64'h0000_0000_FFFE_80F0; cnt = 4'd4; uart = 0; enh = 1; fctl = '0;
    run_frame("R4 enhanced carry", 0);
  endtask

  task automatic t_uart();
    data = 64'h0000_0000_0000_F03C; cnt = 4'd3; uart = 1; enh = 0; fctl = '0;
    data[23:16] = 8'h07;
    run_frame("R5", 0);
  endtask

  task automatic t_gate();
    ident = 6'h05; data = 64'h0000_0000_0000_5A5A; cnt = 4'd2; uart = 0; enh = 0;
    fctl = fw(1, 5'd4, 1, 1, 1, 1, 1, 1, 1);
    run_frame("R6 channel mismatch", 0);
    fctl = fw(0, CH, 1, 1, 1, 1, 1, 1, 1);
    run_frame("R6 not armed", 0);
  endtask

  task automatic t_sync();
    ident = 6'h20; data = 64'h0000_0000_0000_0011; cnt = 4'd1; uart = 0; enh = 0;
    fctl = fw(1, CH, 1, 0, 0, 0, 0, 0, 0);
    run_frame("R7 zero sync", 0);
    fctl = fw(1, CH, 0, 1, 0, 0, 0, 0, 0);
    run_frame("R7 sync stop", 0);
  endtask

  task automatic t_parity();
    ident = 6'h3A; data = 64'h0000_0000_0000_0C03; cnt = 4'd2; uart = 0; enh = 0;
    fctl = fw(1, CH, 0, 0, 1, 0, 0, 0, 0);
    run_frame("R8 LIN", 0);
    uart = 1;
    run_frame("R8 UART", 0);
  endtask

  task automatic t_pid_stop();
    ident = 6'h0F; data = 64'h0000_0000_0000_0042; cnt = 4'd1; uart = 0; enh = 0;
    fctl = fw(1, CH, 0, 0, 0, 1, 0, 0, 0);
    run_frame("R9", 0);
  endtask

  task automatic t_data_stop();
    ident = 6'h01; data = 64'h0000_0000_00FF_0001; cnt = 4'd3; uart = 0; enh = 1;
    fctl = fw(1, CH, 0, 0, 0, 0, 1, 0, 0);
    run_frame("R10 LIN", 0);
    uart = 1;
    run_frame("R10 UART", 0);
  endtask

  task automatic t_sum();
    ident = 6'h15; data = 64'h0000_0000_0000_C3C3; cnt = 4'd2; uart = 0; enh = 1;
    fctl = fw(1, CH, 0, 0, 0, 0, 0, 1, 1);
    run_frame("R11", 0);
    fctl = fw(1, CH, 0, 0, 1, 0, 0, 1, 0);
    run_frame("R11 R8 with enhanced sum", 0);
  endtask

  task automatic t_busy();
    ident = 6'h33; data = 64'h0000_0000_0000_9966; cnt = 4'd2; uart = 0; enh = 0; fctl = '0;
    run_frame("R12 start while busy", 1);
  endtask

  task automatic t_count();
    ident = 6'h2A; data = 64'h0102_0304_0506_0708; cnt = 4'd0; uart = 0; enh = 1; fctl = '0;
    run_frame("R13 header only", 0);
    cnt = 4'd12;
    run_frame("R13 clamp", 0);
    uart = 1; cnt = 4'd0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done && !busy, "R13", "UART empty done", {done, busy}, 2);
    @(negedge clk);
    check(!done && !busy && txd, "R13", "UART empty idle", {done, busy, txd}, 1);
  endtask

  initial begin
    t_reset();
    t_lin_basic();
    t_lin_enh();
    t_uart();
    t_gate();
    t_sync();
    t_parity();
    t_pid_stop();
    t_data_stop();
    t_sum();
    t_busy();
    t_count();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule